// File: doc/BRIEF.md
# Two-Contact Keyboard Velocity Scanner

This block scans a 61-key keyboard whose keys each carry two contacts that close in sequence as the key goes down. It raises one of eight column drive lines at a time. For the active column it samples two banks of eight row inputs: one bank for the upper (early) contacts and one for the lower (late) contacts. Each key gets a small state machine. The number of full scan sweeps between the early contact and the late contact closing is the key's gap. The gap is turned into an 8-bit velocity through one of four selectable curves, or replaced by a fixed velocity when touch sensing is off.

Each key-down and each key-up becomes an event made of a 7-bit note number and a velocity, with velocity zero marking a key-up. Events go into an eight-entry queue. The host sees a valid flag and the head entry, and it pops the head with a one-cycle read strobe. When the queue is full, new events are dropped and a sticky overflow flag is raised.

Top module: `touch_scan`

## Requirements
- R1: After reset `col_drive` is 8'b0000_0001. Exactly one bit is high at all times, and the high bit moves to the next higher position (wrapping from 7 to 0) every DWELL = SETTLE + 8 clock cycles.
- R2: The key at row r and column c has index k = 8*r + c and reports note BASE_NOTE + k (36 by default, so notes run 36..96). Positions with k of 61 or more (row 7, columns 5 to 7) never produce events.
- R3: A key whose early contact closes and whose late contact closes g whole sweeps later produces exactly one key-down event with the velocity of its gap g. If both contacts are seen closed on the same visit, g = 0.
- R4: `touch_mode` encodes the curve: 1 extra-light uses g/4, 2 light uses g/2, 3 normal uses g, 4 heavy uses 2g capped at 255, and 5 to 7 behave as normal. The velocity is 255 minus the scaled gap, or 1 if the scaled gap is 255 or more.
- R5: In modes 1 to 7 the gap counter saturates at 255 sweeps, and a saturated gap always yields velocity 1.
- R6: `touch_mode` = 0 gives every key-down the fixed velocity FIXED_VEL (100 by default), whatever the gap.
- R7: When the early contact of a fully pressed key opens, the key produces a key-up event with velocity 0. If the early contact opens before the late contact has closed, the key returns to idle and produces no event.
- R8: A key that stays fully pressed produces no further events.
- R9: `ev_valid` is high exactly when the queue holds events, and `ev_note`/`ev_vel` show the oldest one. `rd_en` removes one entry, and `rd_en` on an empty queue has no effect.
- R10: An event that arrives while eight entries are held is dropped and sets `ovf`. The stored entries are kept, and `ovf` stays high until reset.
- R11: During and after reset, `ev_valid` and `ovf` are 0 and every key is idle.
- R12: Keys are examined in column order and, within a column, in ascending row order. Events enter the queue in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_mode | input | 3 | Touch curve select (R4 encoding) |
| fc_row | input | 8 | Early-contact row inputs for the driven column, 1 = closed |
| sc_row | input | 8 | Late-contact row inputs for the driven column, 1 = closed |
| rd_en | input | 1 | Pop the head event |
| col_drive | output | 8 | One-hot column drive |
| ev_valid | output | 1 | Queue not empty |
| ev_note | output | 7 | Note number of the head event |
| ev_vel | output | 8 | Velocity of the head event, 0 = key-up |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The bench builds the block with SETTLE = 2, so a column lasts 10 cycles and a sweep lasts 80. A gap of several hundred sweeps, enough to saturate the counter, then fits in a few tens of thousands of cycles. Ten keys pressed together in one sweep exceed the default eight-entry queue, which exercises the drop and sticky flag paths. The default key count puts three unused positions in the top row, so the ignored-position rule is exercised as well.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    localparam int NOTE_W = 7;
    localparam int VEL_W  = 8;
    localparam int GAP_W  = 8;

    typedef enum logic [1:0] {
        K_IDLE   = 2'd0,
        K_TIMING = 2'd1,
        K_DOWN   = 2'd2
    } key_phase_e;

    typedef enum logic [2:0] {
        TM_FIXED  = 3'd0,
        TM_XLIGHT = 3'd1,
        TM_LIGHT  = 3'd2,
        TM_NORMAL = 3'd3,
        TM_HEAVY  = 3'd4
    } touch_mode_e;

    typedef struct packed {
        logic [NOTE_W-1:0] note;
        logic [VEL_W-1:0]  vel;
    } key_event_t;

    // Gap (in sweeps) to key-down velocity for the selected curve.
    function automatic logic [VEL_W-1:0] curve_vel(
        input logic [GAP_W-1:0] gap,
        input logic [2:0]       mode,
        input logic [VEL_W-1:0] fixed_vel
    );
        logic [GAP_W:0] scaled;
        if (mode == 3'd0) return fixed_vel;
        if (gap == '1) return VEL_W'(1);
        case (touch_mode_e'(mode))
            TM_XLIGHT: scaled = {3'b000, gap[GAP_W-1:2]};
            TM_LIGHT:  scaled = {2'b00, gap[GAP_W-1:1]};
            TM_HEAVY:  scaled = {gap, 1'b0};
            default:   scaled = {1'b0, gap};
        endcase
        if (scaled >= (GAP_W+1)'(255)) return VEL_W'(1);
        return VEL_W'((GAP_W+1)'(255) - scaled);
    endfunction

endpackage

// File: rtl/tscan_seq.sv
module tscan_seq #(
    parameter int NCOLS  = 8,
    parameter int NROWS  = 8,
    parameter int SETTLE = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic [NCOLS-1:0]         col_drive,
    output logic [$clog2(NCOLS)-1:0] col_idx,
    output logic [$clog2(NROWS)-1:0] proc_row,
    output logic                     snap_en,
    output logic                     proc_en
);
    localparam int DWELL = SETTLE + NROWS;
    localparam int SUB_W = $clog2(DWELL);
    localparam int COL_W = $clog2(NCOLS);
    localparam int ROW_W = $clog2(NROWS);

    logic [SUB_W-1:0] sub;
    logic [COL_W-1:0] col;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub <= '0;
            col <= '0;
        end else if (sub == SUB_W'(DWELL - 1)) begin
            sub <= '0;
            col <= (col == COL_W'(NCOLS - 1)) ? '0 : col + COL_W'(1);
        end else begin
            sub <= sub + SUB_W'(1);
        end
    end

    for (genvar g = 0; g < NCOLS; g++) begin : g_drive
        assign col_drive[g] = (col == COL_W'(g));
    end

    assign col_idx  = col;
    assign snap_en  = (sub == SUB_W'(SETTLE - 1));
    assign proc_en  = (sub >= SUB_W'(SETTLE));
    assign proc_row = ROW_W'(sub - SUB_W'(SETTLE));

endmodule

// File: rtl/tscan_keys.sv
module tscan_keys
    import tscan_pkg::*;
#(
    parameter int NCOLS     = 8,
    parameter int NROWS     = 8,
    parameter int NKEYS     = 61,
    parameter int BASE_NOTE = 36,
    parameter int FIXED_VEL = 100
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NROWS-1:0]         fc_row,
    input  logic [NROWS-1:0]         sc_row,
    input  logic [2:0]               mode,
    input  logic                     snap_en,
    input  logic                     proc_en,
    input  logic [$clog2(NROWS)-1:0] proc_row,
    input  logic [$clog2(NCOLS)-1:0] col_idx,
    output logic                     ev_push,
    output key_event_t               ev_data
);
    localparam int SLOTS = NROWS * NCOLS;
    localparam int KEY_W = $clog2(SLOTS);

    key_phase_e        phase [SLOTS];
    logic [GAP_W-1:0]  gap   [SLOTS];
    logic [NROWS-1:0]  snap_f, snap_s;

    logic [KEY_W-1:0]  kidx;
    logic              key_ok;
    logic              f, s, push_raw;
    key_phase_e        cur_ph, nxt_ph;
    logic [GAP_W-1:0]  cur_gap, nxt_gap, bumped;
    logic [VEL_W-1:0]  vel;

    assign kidx   = KEY_W'(proc_row) * KEY_W'(NCOLS) + KEY_W'(col_idx);
    assign key_ok = proc_en && (32'(kidx) < NKEYS);

    always_comb begin
        f       = snap_f[proc_row];
        s       = snap_s[proc_row];
        cur_ph  = phase[kidx];
        cur_gap = gap[kidx];
        bumped  = (cur_gap == '1) ? cur_gap : cur_gap + GAP_W'(1);
        nxt_ph  = cur_ph;
        nxt_gap = cur_gap;
        push_raw = 1'b0;
        vel     = '0;
        case (cur_ph)
            K_IDLE: begin
                if (f) begin
                    if (s) begin
                        nxt_ph   = K_DOWN;
                        push_raw = 1'b1;
                        vel      = curve_vel('0, mode, VEL_W'(FIXED_VEL));
                    end else begin
                        nxt_ph  = K_TIMING;
                        nxt_gap = '0;
                    end
                end
            end
            K_TIMING: begin
                if (!f) begin
                    nxt_ph = K_IDLE;
                end else if (s) begin
                    nxt_ph   = K_DOWN;
                    push_raw = 1'b1;
                    vel      = curve_vel(bumped, mode, VEL_W'(FIXED_VEL));
                end else begin
                    nxt_gap = bumped;
                end
            end
            K_DOWN: begin
                if (!f) begin
                    nxt_ph   = K_IDLE;
                    push_raw = 1'b1;
                    vel      = '0;
                end
            end
            default: nxt_ph = K_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                phase[i] <= K_IDLE;
                gap[i]   <= '0;
            end
            snap_f <= '0;
            snap_s <= '0;
        end else begin
            if (snap_en) begin
                snap_f <= fc_row;
                snap_s <= sc_row;
            end
            if (key_ok) begin
                phase[kidx] <= nxt_ph;
                gap[kidx]   <= nxt_gap;
            end
        end
    end

    assign ev_push      = push_raw && key_ok;
    assign ev_data.note = NOTE_W'(BASE_NOTE) + NOTE_W'(kidx);
    assign ev_data.vel  = vel;

endmodule

// File: rtl/tscan_fifo.sv
module tscan_fifo
    import tscan_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  key_event_t din,
    input  logic       pop,
    output key_event_t dout,
    output logic       not_empty,
    output logic       full,
    output logic       ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    key_event_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign dout      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            if (push && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/touch_scan.sv
module touch_scan
    import tscan_pkg::*;
#(
    parameter int NCOLS     = 8,
    parameter int NROWS     = 8,
    parameter int NKEYS     = 61,
    parameter int SETTLE    = 4,
    parameter int BASE_NOTE = 36,
    parameter int FIXED_VEL = 100,
    parameter int QDEPTH    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        touch_mode,
    input  logic [NROWS-1:0]  fc_row,
    input  logic [NROWS-1:0]  sc_row,
    input  logic              rd_en,
    output logic [NCOLS-1:0]  col_drive,
    output logic              ev_valid,
    output logic [NOTE_W-1:0] ev_note,
    output logic [VEL_W-1:0]  ev_vel,
    output logic              ovf
);
    logic [$clog2(NCOLS)-1:0] col_idx;
    logic [$clog2(NROWS)-1:0] proc_row;
    logic                     snap_en, proc_en;
    logic                     ev_push, q_full;
    key_event_t               ev_data, head;

    tscan_seq #(.NCOLS(NCOLS), .NROWS(NROWS), .SETTLE(SETTLE)) i_seq (
        .clk(clk), .rst(rst), .col_drive(col_drive), .col_idx(col_idx),
        .proc_row(proc_row), .snap_en(snap_en), .proc_en(proc_en)
    );

    tscan_keys #(
        .NCOLS(NCOLS), .NROWS(NROWS), .NKEYS(NKEYS),
        .BASE_NOTE(BASE_NOTE), .FIXED_VEL(FIXED_VEL)
    ) i_keys (
        .clk(clk), .rst(rst), .fc_row(fc_row), .sc_row(sc_row),
        .mode(touch_mode), .snap_en(snap_en), .proc_en(proc_en),
        .proc_row(proc_row), .col_idx(col_idx),
        .ev_push(ev_push), .ev_data(ev_data)
    );

    tscan_fifo #(.DEPTH(QDEPTH)) i_fifo (
        .clk(clk), .rst(rst), .push(ev_push), .din(ev_data), .pop(rd_en),
        .dout(head), .not_empty(ev_valid), .full(q_full), .ovf(ovf)
    );

    assign ev_note = head.note;
    assign ev_vel  = head.vel;

endmodule

// File: rtl/touch_scan_chk.sv
module touch_scan_chk
    import tscan_pkg::*;
#(
    parameter int NCOLS     = 8,
    parameter int NKEYS     = 61,
    parameter int BASE_NOTE = 36
) (
    input logic              clk,
    input logic              rst,
    input logic [NCOLS-1:0]  col_drive,
    input logic              ev_push,
    input key_event_t        ev_data,
    input logic              q_full,
    input logic              rd_en,
    input logic              ev_valid,
    input logic [NOTE_W-1:0] ev_note,
    input logic [VEL_W-1:0]  ev_vel,
    input logic              ovf
);
    logic [NCOLS-1:0] rot;
    assign rot = {col_drive[NCOLS-2:0], col_drive[NCOLS-1]};

    // R1
    col_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(col_drive) == 1);

    // R1
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(col_drive) |-> (col_drive == $past(rot)));

    // R2
    note_range_chk: assert property (@(posedge clk) disable iff (rst)
        ev_push |-> (32'(ev_data.note) >= BASE_NOTE && 32'(ev_data.note) < BASE_NOTE + NKEYS));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !rd_en) |=> (ev_valid && $stable(ev_note) && $stable(ev_vel)));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev_valid && rd_en && !ev_push) |=> !ev_valid);

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_push && q_full) |=> ovf);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

endmodule

bind touch_scan touch_scan_chk #(
    .NCOLS(NCOLS), .NKEYS(NKEYS), .BASE_NOTE(BASE_NOTE)
) i_touch_scan_chk (
    .clk(clk), .rst(rst), .col_drive(col_drive), .ev_push(ev_push),
    .ev_data(ev_data), .q_full(q_full), .rd_en(rd_en), .ev_valid(ev_valid),
    .ev_note(ev_note), .ev_vel(ev_vel), .ovf(ovf)
);

// File: tb/test_touch_scan.sv
module test_touch_scan;

    localparam int SETTLE = 2;
    localparam int SWEEP  = (SETTLE + 8) * 8;
    localparam int NK     = 61;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] touch_mode = 3'd3;
    logic [7:0] fc_row, sc_row;
    logic       rd_en = 1'b0;
    logic [7:0] col_drive;
    logic       ev_valid;
    logic [6:0] ev_note;
    logic [7:0] ev_vel;
    logic       ovf;

    logic kf [64];
    logic ks [64];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    touch_scan #(.SETTLE(SETTLE)) i_touch_scan (
        .clk(clk), .rst(rst), .touch_mode(touch_mode), .fc_row(fc_row),
        .sc_row(sc_row), .rd_en(rd_en), .col_drive(col_drive),
        .ev_valid(ev_valid), .ev_note(ev_note), .ev_vel(ev_vel), .ovf(ovf)
    );

    // keyboard: rows reflect the driven column
    always_comb begin
        int c;
        c = 0;
        for (int i = 0; i < 8; i++) if (col_drive[i]) c = i;
        for (int r = 0; r < 8; r++) begin
            fc_row[r] = kf[r*8 + c];
            sc_row[r] = ks[r*8 + c];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_vel(input int g, input int mode);
        int s;
        if (mode == 0) return 100;
        if (g >= 255) return 1;
        case (mode)
            1: s = g / 4;
            2: s = g / 2;
            4: s = (2 * g > 255) ? 255 : 2 * g;
            default: s = g;
        endcase
        return (s >= 255) ? 1 : 255 - s;
    endfunction

    // behavioural reference model
    typedef struct { int n; int v; } mev_t;
    mev_t mq[$];
    int   m_sub, m_col;
    int   m_st [64];
    int   m_tm [64];
    bit   m_ovf;
    bit   mf [8];
    bit   ms [8];

    always @(posedge clk) begin
        int  r, k, sz, t, pn, pvl;
        bit  dpop, pv;
        cyc++;
        if (rst) begin
            m_sub = 0; m_col = 0; m_ovf = 0;
            mq.delete();
            for (int i = 0; i < 64; i++) begin m_st[i] = 0; m_tm[i] = 0; end
        end else begin
            sz = mq.size();
            dpop = rd_en && sz > 0;
            pv = 0; pn = 0; pvl = 0;
            if (m_sub == SETTLE - 1)
                for (int j = 0; j < 8; j++) begin
                    mf[j] = kf[j*8 + m_col];
                    ms[j] = ks[j*8 + m_col];
                end
            if (m_sub >= SETTLE) begin
                r = m_sub - SETTLE;
                k = r * 8 + m_col;
                if (k < NK) begin
                    pn = 36 + k;
                    case (m_st[k])
                        0: if (mf[r]) begin
                               if (ms[r]) begin m_st[k] = 2; pv = 1; pvl = exp_vel(0, int'(touch_mode)); end
                               else begin m_st[k] = 1; m_tm[k] = 0; end
                           end
                        1: if (!mf[r]) m_st[k] = 0;
                           else begin
                               t = (m_tm[k] >= 255) ? 255 : m_tm[k] + 1;
                               if (ms[r]) begin m_st[k] = 2; pv = 1; pvl = exp_vel(t, int'(touch_mode)); end
                               else m_tm[k] = t;
                           end
                        default: if (!mf[r]) begin m_st[k] = 0; pv = 1; pvl = 0; end
                    endcase
                end
            end
            if (dpop) void'(mq.pop_front());
            if (pv) begin
                if (sz < 8) mq.push_back('{n: pn, v: pvl});
                else m_ovf = 1;
            end
            if (m_sub == SETTLE + 7) begin
                m_sub = 0;
                m_col = (m_col + 1) % 8;
            end else m_sub++;
        end
        if (cyc == 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(col_drive == 8'(1 << m_col), "R1 column drive", int'(col_drive), 1 << m_col);
            check(ev_valid == (mq.size() > 0), "R9 valid flag", int'(ev_valid), int'(mq.size() > 0));
            if (mq.size() > 0)
                check(int'(ev_note) == mq[0].n && int'(ev_vel) == mq[0].v, "R12 head event",
                      int'(ev_note) * 1000 + int'(ev_vel), mq[0].n * 1000 + mq[0].v);
            check(ovf == m_ovf, "R10 overflow flag", int'(ovf), int'(m_ovf));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_gap(input int k, input int g);
        kf[k] = 1'b1;
        if (g > 0) wait_cyc(g * SWEEP);
        ks[k] = 1'b1;
    endtask

    task automatic lift(input int k);
        kf[k] = 1'b0;
        ks[k] = 1'b0;
    endtask

    task automatic pop_expect(input int n, input int v, input string req);
        int w;
        w = 0;
        while (!ev_valid && w < 3 * SWEEP) begin @(negedge clk); w++; end
        check(ev_valid == 1'b1, req, int'(ev_valid), 1);
        check(int'(ev_note) == n, req, int'(ev_note), n);
        check(int'(ev_vel) == v, req, int'(ev_vel), v);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic sync_col0();
        while (col_drive == 8'd1) @(negedge clk);
        while (col_drive != 8'd1) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin kf[i] = 1'b0; ks[i] = 1'b0; end
        wait_cyc(3);
        // R11: reset state
        check(col_drive == 8'd1, "R11 reset column", int'(col_drive), 1);
        check(ev_valid == 1'b0, "R11 reset valid", int'(ev_valid), 0);
        check(ovf == 1'b0, "R11 reset ovf", int'(ovf), 0);
        rst = 1'b0;
        wait_cyc(2);

        // R3: simultaneous contacts, then R7 release
        press_gap(0, 0);
        pop_expect(36, 255, "R3 gap0 key-down");
        lift(0);
        pop_expect(36, 0, "R7 key-up");

        // R3 gap 3, R8 hold
        press_gap(10, 3);
        pop_expect(46, 252, "R3 gap3 key-down");
        wait_cyc(3 * SWEEP);
        check(ev_valid == 1'b0, "R8 held key silent", int'(ev_valid), 0);
        lift(10);
        pop_expect(46, 0, "R7 key-up");

        // R4 curves
        touch_mode = 3'd1;
        press_gap(5, 40); pop_expect(41, 245, "R4 extra-light"); lift(5); pop_expect(41, 0, "R7 key-up");
        touch_mode = 3'd2;
        press_gap(5, 40); pop_expect(41, 235, "R4 light"); lift(5); pop_expect(41, 0, "R7 key-up");
        touch_mode = 3'd4;
        press_gap(5, 40); pop_expect(41, 175, "R4 heavy"); lift(5); pop_expect(41, 0, "R7 key-up");
        press_gap(5, 200); pop_expect(41, 1, "R4 heavy capped"); lift(5); pop_expect(41, 0, "R7 key-up");

        // R6 fixed velocity
        touch_mode = 3'd0;
        press_gap(7, 5); pop_expect(43, 100, "R6 fixed"); lift(7); pop_expect(43, 0, "R7 key-up");

        // R5 saturation
        touch_mode = 3'd3;
        press_gap(20, 300); pop_expect(56, 1, "R5 saturated"); lift(20); pop_expect(56, 0, "R7 key-up");

        // R7 aborted press
        kf[30] = 1'b1;
        wait_cyc(2 * SWEEP);
        kf[30] = 1'b0;
        wait_cyc(2 * SWEEP);
        check(ev_valid == 1'b0, "R7 aborted press silent", int'(ev_valid), 0);

        // R2 unused positions and top key
        for (int k = 61; k < 64; k++) press_gap(k, 0);
        wait_cyc(2 * SWEEP);
        check(ev_valid == 1'b0, "R2 unused positions", int'(ev_valid), 0);
        for (int k = 61; k < 64; k++) lift(k);
        press_gap(60, 0); pop_expect(96, 255, "R2 top key"); lift(60); pop_expect(96, 0, "R7 key-up");

        // R12 ordering
        sync_col0();
        press_gap(9, 0); press_gap(1, 0); press_gap(2, 0);
        pop_expect(37, 255, "R12 order first");
        pop_expect(45, 255, "R12 order second");
        pop_expect(38, 255, "R12 order third");
        lift(1); lift(2); lift(9);
        wait_cyc(SWEEP);
        for (int i = 0; i < 3; i++) begin rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk); end

        // R10 overflow
        sync_col0();
        for (int k = 0; k < 10; k++) press_gap(k, 0);
        wait_cyc(2 * SWEEP);
        check(ovf == 1'b1, "R10 overflow set", int'(ovf), 1);
        pop_expect(36, 255, "R10 kept 1");
        pop_expect(44, 255, "R10 kept 2");
        pop_expect(37, 255, "R10 kept 3");
        pop_expect(45, 255, "R10 kept 4");
        pop_expect(38, 255, "R10 kept 5");
        pop_expect(39, 255, "R10 kept 6");
        pop_expect(40, 255, "R10 kept 7");
        pop_expect(41, 255, "R10 kept 8");
        check(ev_valid == 1'b0, "R10 dropped events", int'(ev_valid), 0);

        // R9 pop on empty
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        check(ev_valid == 1'b0, "R9 empty pop", int'(ev_valid), 0);
        check(ovf == 1'b1, "R10 sticky", int'(ovf), 1);

        for (int k = 0; k < 10; k++) lift(k);
        for (int i = 0; i < 3 * SWEEP; i++) begin
            rd_en = ev_valid;
            @(negedge clk);
        end
        rd_en = 1'b0;
        wait_cyc(4);
        check(ev_valid == 1'b0, "R9 drained", int'(ev_valid), 0);
        finish_run();
    end

endmodule